// File: doc/BRIEF.md
# Dual Clock-Enable Divider

This block derives two slower clock enables from one fast reference enable: a core enable and a system enable. Both are single-cycle qualifiers in the clock domain of `clk`. Each counts reference pulses and fires once per programmed number of them. The core path divides by a power of two, chosen by a 2-bit select code. The system path divides by any integer from 1 to 15, chosen by a 4-bit select code. The system code of zero is reserved.

Software writes one small select word at any time, with no special sequence. Each path keeps a pending code and an active code. A newly written code becomes active only when that path's current period ends, so no shortened pulse appears. A read-back port shows the active codes, so software can see when a change has applied. A write that carries the reserved system code leaves the system ratio as it was and raises a sticky error flag.

Top module: `dual_clk_divider`

## Requirements
- R1: After reset the active core code is 0 (divide by 1), the active system code is 5 (divide by 5), and `sel_err` is low.
- R2: The core path asserts `core_en` once every 2^C reference pulses, where C is the 2-bit core code (0..3 gives 1, 2, 4, 8).
- R3: The system path asserts `sys_en` once every N reference pulses, where N is the 4-bit system code, for every N from 1 to 15.
- R4: With a ratio of 1, the enable follows `ref_en` every cycle. With `ref_en` held high, it stays high continuously.
- R5: An enable is only ever high in a cycle where `ref_en` is high, and its pulse count over a window is the number of reference pulses divided by the ratio.
- R6: A write may happen at any cycle. The period in progress completes at the old ratio, the new ratio governs from the next pulse of that output, and the active code changes only in the cycle after that output pulses.
- R7: A write whose system field (bits [5:2]) is 0 leaves the system ratio and its active code unchanged and sets `sel_err`. The core field (bits [1:0]) of the same write is still accepted.
- R8: `sel_err` stays high until a write with a nonzero system field, which clears it. Other writes and elapsed time leave it unchanged.
- R9: `rd_data` returns the active codes, with the core code in bits [1:0] and the system code in bits [5:2]. Pending codes are not shown.
- R10: The two paths run independently. Rewriting the system code does not change the core enable's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference-rate enable counted by both dividers |
| wr_en | input | 1 | Write strobe for the select word |
| wr_data | input | 6 | Select word: core code [1:0], system code [5:2] |
| core_en | output | 1 | Core-rate enable pulse |
| sys_en | output | 1 | System-rate enable pulse |
| rd_data | output | 6 | Active codes, same layout as `wr_data` |
| sel_err | output | 1 | Sticky flag for a rejected reserved system code |

## Verification
The bench builds the block with its default parameters: a 2-bit power-of-two core field, a 4-bit linear system field, and reset codes 0 and 5. These widths bring every legal ratio within reach, including the longest core count of 8 and the longest system count of 15. With `ref_en` held high, the bench measures the period for every legal code. With `ref_en` toggling, it shows that the enables count reference pulses and not clock cycles. Mid-period rewrites show the old period finishing before the new one starts.

// File: rtl/dual_clk_div_pkg.sv
package dual_clk_div_pkg;
   typedef enum logic {
      DIV_POW2   = 1'b0,
      DIV_LINEAR = 1'b1
   } div_mode_e;

   function automatic int max_ratio(input div_mode_e mode, input int code_w);
      if (mode == DIV_POW2) return 1 << ((1 << code_w) - 1);
      else                  return (1 << code_w) - 1;
   endfunction
endpackage

// File: rtl/dual_div_ctl.sv
module dual_div_ctl #(
   parameter int CORE_SEL_W = 2,
   parameter int SYS_SEL_W  = 4,
   parameter int CORE_RST   = 0,
   parameter int SYS_RST    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [CORE_SEL_W-1:0] wr_core,
   input  logic [SYS_SEL_W-1:0]  wr_sys,
   output logic [CORE_SEL_W-1:0] pend_core,
   output logic [SYS_SEL_W-1:0]  pend_sys,
   output logic                  err
);
   logic sys_zero;
   assign sys_zero = (wr_sys == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_core <= CORE_SEL_W'(CORE_RST);
         pend_sys  <= SYS_SEL_W'(SYS_RST);
         err       <= 1'b0;
      end else if (wr_en) begin
         pend_core <= wr_core;
         if (sys_zero) begin
            err <= 1'b1;
         end else begin
            pend_sys <= wr_sys;
            err      <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dual_div_path.sv
module dual_div_path
   import dual_clk_div_pkg::*;
#(
   parameter div_mode_e MODE     = DIV_POW2,
   parameter int        CODE_W   = 2,
   parameter int        RST_CODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic [CODE_W-1:0] pend_code,
   output logic [CODE_W-1:0] act_code,
   output logic              tick
);
   localparam int MAX_R = max_ratio(MODE, CODE_W);
   localparam int CNT_W = (MAX_R > 2) ? $clog2(MAX_R) : 1;
   localparam int R_W   = CNT_W + 1;

   logic [R_W-1:0]   pend_ratio;
   logic [R_W-1:0]   act_ratio;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;

   generate
      if (MODE == DIV_POW2) begin : g_pow2
         assign pend_ratio = R_W'(1) << pend_code;
         assign act_ratio  = R_W'(1) << act_code;
      end else begin : g_linear
         assign pend_ratio = R_W'(pend_code);
         assign act_ratio  = R_W'(act_code);
      end
   endgenerate

   assign last_cnt = CNT_W'(act_ratio - R_W'(1));
   assign tick     = ref_en && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_code <= CODE_W'(RST_CODE);
         cnt_q    <= '0;
      end else if (ref_en) begin
         if (cnt_q == '0) begin
            act_code <= pend_code;
            cnt_q    <= (pend_ratio == R_W'(1)) ? '0 : CNT_W'(1);
         end else if (cnt_q == last_cnt) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
   import dual_clk_div_pkg::*;
#(
   parameter int CORE_SEL_W = 2,
   parameter int SYS_SEL_W  = 4,
   parameter int CORE_RST   = 0,
   parameter int SYS_RST    = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ref_en,
   input  logic                            wr_en,
   input  logic [CORE_SEL_W+SYS_SEL_W-1:0] wr_data,
   output logic                            core_en,
   output logic                            sys_en,
   output logic [CORE_SEL_W+SYS_SEL_W-1:0] rd_data,
   output logic                            sel_err
);
   localparam int REG_W = CORE_SEL_W + SYS_SEL_W;

   generate
      if (CORE_SEL_W < 1 || CORE_SEL_W > 3) begin : g_bad_core_w
         $error("CORE_SEL_W must be 1..3");
      end
      if (SYS_SEL_W < 2 || SYS_SEL_W > 8) begin : g_bad_sys_w
         $error("SYS_SEL_W must be 2..8");
      end
      if (SYS_RST < 1 || SYS_RST >= (1 << SYS_SEL_W)) begin : g_bad_sys_rst
         $error("SYS_RST must be a nonzero code");
      end
      if (CORE_RST < 0 || CORE_RST >= (1 << CORE_SEL_W)) begin : g_bad_core_rst
         $error("CORE_RST out of range");
      end
   endgenerate

   logic [CORE_SEL_W-1:0] pend_core, act_core;
   logic [SYS_SEL_W-1:0]  pend_sys, act_sys;

   dual_div_ctl #(
      .CORE_SEL_W(CORE_SEL_W), .SYS_SEL_W(SYS_SEL_W),
      .CORE_RST(CORE_RST),     .SYS_RST(SYS_RST)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_core(wr_data[CORE_SEL_W-1:0]),
      .wr_sys(wr_data[REG_W-1:CORE_SEL_W]),
      .pend_core(pend_core), .pend_sys(pend_sys), .err(sel_err)
   );

   dual_div_path #(.MODE(DIV_POW2), .CODE_W(CORE_SEL_W), .RST_CODE(CORE_RST)) u_core (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
      .pend_code(pend_core), .act_code(act_core), .tick(core_en)
   );

   dual_div_path #(.MODE(DIV_LINEAR), .CODE_W(SYS_SEL_W), .RST_CODE(SYS_RST)) u_sys (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
      .pend_code(pend_sys), .act_code(act_sys), .tick(sys_en)
   );

   assign rd_data = {act_sys, act_core};
endmodule

// File: rtl/dual_clk_divider_chk.sv
module dual_clk_divider_chk #(
   parameter int CORE_SEL_W = 2,
   parameter int SYS_SEL_W  = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            ref_en,
   input logic                            wr_en,
   input logic [CORE_SEL_W+SYS_SEL_W-1:0] wr_data,
   input logic                            core_en,
   input logic                            sys_en,
   input logic [CORE_SEL_W+SYS_SEL_W-1:0] rd_data,
   input logic                            sel_err
);
   localparam int REG_W = CORE_SEL_W + SYS_SEL_W;

   p_core_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |-> ref_en);
   p_sys_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_en |-> ref_en);
   p_sys_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:CORE_SEL_W] != '0);
   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[REG_W-1:CORE_SEL_W] == '0) |=> sel_err);
   p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[REG_W-1:CORE_SEL_W] != '0) |=> !sel_err);
   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sel_err));
   p_core_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> $stable(rd_data[CORE_SEL_W-1:0]));
   p_sys_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_en |=> $stable(rd_data[REG_W-1:CORE_SEL_W]));
endmodule

bind dual_clk_divider dual_clk_divider_chk #(
   .CORE_SEL_W(CORE_SEL_W), .SYS_SEL_W(SYS_SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
   .wr_data(wr_data), .core_en(core_en), .sys_en(sys_en),
   .rd_data(rd_data), .sel_err(sel_err)
);

// File: tb/sim_dual_clk_divider.sv
module sim_dual_clk_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [5:0] wr_data = '0;
   logic       core_en, sys_en, sel_err;
   logic [5:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc_n  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc_n <= cyc_n + 1;

   dual_clk_divider u0 (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
      .wr_data(wr_data), .core_en(core_en), .sys_en(sys_en),
      .rd_data(rd_data), .sel_err(sel_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      #2;
   endtask

   task automatic wr(input int sys, input int core);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = {sys[3:0], core[1:0]};
      @(negedge clk);
      wr_en   = 1'b0;
      #2;
   endtask

   task automatic sync(input bit which);
      for (int i = 0; i < 100; i++) begin
         cyc();
         if ((which ? sys_en : core_en) == 1'b1) break;
      end
   endtask

   task automatic gap(input bit which, output int g);
      sync(which);
      g = 0;
      for (int i = 0; i < 100; i++) begin
         cyc();
         g++;
         if ((which ? sys_en : core_en) == 1'b1) break;
      end
   endtask

   task automatic t_reset();
      chk("R1 core code", int'(rd_data[1:0]), 0);
      chk("R1 sys code", int'(rd_data[5:2]), 5);
      chk("R1 err", int'(sel_err), 0);
   endtask

   task automatic t_core_ratios();
      int g;
      for (int c = 0; c < 4; c++) begin
         wr(5, c);
         gap(1'b0, g);
         gap(1'b0, g);
         chk($sformatf("R2 core gap code %0d", c), g, 1 << c);
         chk("R9 core readback", int'(rd_data[1:0]), c);
      end
      wr(5, 0);
      gap(1'b0, g);
      begin
         int hi = 0;
         for (int i = 0; i < 12; i++) begin
            cyc();
            hi += int'(core_en);
         end
         chk("R4 core continuous", hi, 12);
      end
   endtask

   task automatic t_sys_ratios();
      int g;
      for (int n = 1; n < 16; n++) begin
         wr(n, 0);
         gap(1'b1, g);
         gap(1'b1, g);
         chk($sformatf("R3 sys gap code %0d", n), g, n);
         chk("R9 sys readback", int'(rd_data[5:2]), n);
      end
      begin
         int hi = 0;
         wr(1, 0);
         gap(1'b1, g);
         for (int i = 0; i < 10; i++) begin
            cyc();
            hi += int'(sys_en);
         end
         chk("R4 sys continuous", hi, 10);
      end
   endtask

   task automatic t_ref_gate();
      int g;
      int nc = 0, ns = 0, bad = 0;
      wr(5, 1);
      gap(1'b1, g);
      gap(1'b0, g);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         ref_en = (i % 2 == 0);
         #2;
         if ((core_en || sys_en) && !ref_en) bad++;
         nc += int'(core_en);
         ns += int'(sys_en);
      end
      @(negedge clk);
      ref_en = 1'b1;
      chk("R5 enable outside ref_en", bad, 0);
      chk("R5 core pulses per 20 refs", nc, 10);
      chk("R5 sys pulses per 20 refs", ns, 4);
   endtask

   task automatic t_change();
      int g, t0, g1;
      wr(5, 2);
      gap(1'b1, g);
      gap(1'b0, g);
      chk("R10 core gap before", g, 4);
      sync(1'b1);
      t0 = cyc_n;
      wr(3, 2);
      chk("R9 pending not shown", int'(rd_data[5:2]), 5);
      for (int i = 0; i < 100; i++) begin
         if (sys_en) break;
         cyc();
      end
      g1 = cyc_n - t0;
      chk("R6 old period completes", g1, 5);
      chk("R6 code still old at pulse", int'(rd_data[5:2]), 5);
      cyc();
      chk("R6 code active after pulse", int'(rd_data[5:2]), 3);
      t0 = cyc_n;
      for (int i = 0; i < 100; i++) begin
         if (sys_en) break;
         cyc();
      end
      chk("R6 new period", cyc_n - t0, 2);
      gap(1'b1, g);
      chk("R3 sys gap after change", g, 3);
      gap(1'b0, g);
      chk("R10 core gap after sys write", g, 4);
   endtask

   task automatic t_reserved();
      int g;
      wr(0, 1);
      chk("R7 err set", int'(sel_err), 1);
      gap(1'b1, g);
      gap(1'b1, g);
      chk("R7 sys ratio kept", g, 3);
      chk("R7 sys code kept", int'(rd_data[5:2]), 3);
      gap(1'b0, g);
      gap(1'b0, g);
      chk("R7 core field taken", g, 2);
      chk("R7 core code readback", int'(rd_data[1:0]), 1);
      for (int i = 0; i < 20; i++) cyc();
      chk("R8 err sticky over time", int'(sel_err), 1);
      wr(0, 1);
      chk("R8 err after second reserved", int'(sel_err), 1);
      wr(7, 1);
      chk("R8 err cleared", int'(sel_err), 0);
      gap(1'b1, g);
      gap(1'b1, g);
      chk("R3 sys gap 7 after clear", g, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_core_ratios();
      t_sys_ratios();
      t_ref_gate();
      t_change();
      t_reserved();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule